// File: doc/BRIEF.md
# Synchronous Exception Entry State Update

This unit performs the state capture and redirection a processor core needs when it takes a synchronous exception. When the core's exception logic raises a one-cycle accept strobe, the unit registers the faulting instruction's effective address into save/restore register 0. It registers a masked copy of the machine state into save/restore register 1. It also produces the new machine state value and the fetch address of the exception vector. All of these are updated in the clock edge that samples the strobe.

The unit handles two causes. The first is a trace-style cause that vectors to offset 0xD00. The second is a software-emulation cause that vectors to offset 0x1000. The emulation cause is classified inside the unit from decode hints: an unimplemented or illegal opcode, any floating-point opcode, or a special-register move that targets an unimplemented register, qualified by where that register lives, by bit 0 of its register number and by the privilege bit. There is no separate floating-point assist cause.

Machine state bits use big-endian numbering, so architectural bit b sits at vector index 31-b. The bits used are: interrupt prefix IP (bit 25, index 6), machine-check enable ME (bit 19, index 12), privilege PR (bit 17, index 14), interrupt little-endian ILE (bit 15, index 16), recoverable RI (bit 30, index 1) and little-endian LE (bit 31, index 0).

Top module: `exc_entry_unit`

## Requirements
- R1: An accept with the unimplemented/illegal opcode hint or the floating-point opcode hint raises the emulation cause (emu_o=1, vector offset 0x1000); floating-point opcodes never use any other cause.
- R2: An accept of a special-register move to an unimplemented on-core register raises the emulation cause whatever the register-number bit 0 and PR are.
- R3: An accept of a special-register move to an unimplemented off-core register raises the emulation cause only when register-number bit 0 is 0 or PR (index 14) is 0; with both at 1 and no other cause, nothing is taken.
- R4: On a taken exception, srr0_o holds the effective address presented with the accept.
- R5: On a taken exception, srr1_o indices 31..16 (architectural bits 0-15, which include the cleared bits 1-4 and 10-15) are 0, and indices 15..0 equal msr_i indices 15..0, so SRR1 bit 30 follows RI.
- R6: On a taken exception, msr_o keeps IP (index 6) and ME (index 12), sets LE (index 0) to ILE (msr_i index 16), and clears every other bit.
- R7: vec_o is the base plus the offset, where the base is 0x00000000 when IP is 0 and 0xFFF00000 when IP is 1.
- R8: An accept with trace_i alone vectors to offset 0xD00 with emu_o=0; when trace_i and an emulation condition meet, the emulation cause wins.
- R9: take_o pulses for exactly one cycle after a taken accept. Without a taken accept, including an accept with no cause, all outputs hold their values.
- R10: After synchronous reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept_i | input | 1 | One-cycle exception accept strobe |
| trace_i | input | 1 | Trace-style cause request |
| ea_i | input | 32 | Effective address of the faulting instruction |
| msr_i | input | 32 | Current machine state |
| op_unimpl_i | input | 1 | Decode: unimplemented or illegal opcode |
| op_fp_i | input | 1 | Decode: floating-point opcode |
| spr_move_i | input | 1 | Decode: move to or from a special register |
| spr_unimpl_i | input | 1 | The addressed special register is not implemented |
| spr_oncore_i | input | 1 | The addressed special register is located on-core |
| spr_num0_i | input | 1 | Bit 0 of the special-register number |
| take_o | output | 1 | Pulse: exception taken, registers updated |
| emu_o | output | 1 | Cause of the last taken exception is emulation |
| srr0_o | output | 32 | Save/restore register 0 |
| srr1_o | output | 32 | Save/restore register 1 |
| msr_o | output | 32 | New machine state |
| vec_o | output | 32 | Vector fetch address |

## Verification
The assertions assume that accept_i is a single-cycle pulse and that the decode hints and msr_i are stable and meaningful in the cycle the strobe is high. The spr_unimpl_i, spr_oncore_i and spr_num0_i hints are only relevant while spr_move_i is high. The bench drives every field at the falling edge and raises accept_i for exactly one cycle, then idles at least one cycle before the next accept. Each scenario sets only the hint combination it means to test and clears the others.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // Machine state bit indices (vector index = 31 - architectural bit).
  localparam int MSR_W    = 32;
  localparam int IDX_LE   = 0;
  localparam int IDX_RI   = 1;
  localparam int IDX_IP   = 6;
  localparam int IDX_ME   = 12;
  localparam int IDX_PR   = 14;
  localparam int IDX_ILE  = 16;
  // Bits of the state copied into SRR1 (architectural bits 16-31).
  localparam logic [MSR_W-1:0] SRR1_COPY_MASK = 32'h0000_FFFF;
  // Bits of the state kept across entry.
  localparam logic [MSR_W-1:0] MSR_KEEP_MASK =
    (MSR_W'(1) << IDX_IP) | (MSR_W'(1) << IDX_ME);

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_TRACE = 2'd1,
    CAUSE_EMU   = 2'd2
  } cause_e;

  typedef struct packed {
    logic [MSR_W-1:0] srr1;
    logic [MSR_W-1:0] msr;
  } entry_state_t;
endpackage

// File: rtl/exc_emu_classify.sv
module exc_emu_classify (
  input  logic op_unimpl_i,
  input  logic op_fp_i,
  input  logic spr_move_i,
  input  logic spr_unimpl_i,
  input  logic spr_oncore_i,
  input  logic spr_num0_i,
  input  logic priv_pr_i,
  output logic emu_o
);
  logic spr_gate;
  logic spr_trap;

  // Off-core registers trap only for number bit 0 clear or supervisor state.
  always_comb begin
    spr_gate = spr_oncore_i | ~spr_num0_i | ~priv_pr_i;
    spr_trap = spr_move_i & spr_unimpl_i & spr_gate;
    emu_o    = op_unimpl_i | op_fp_i | spr_trap;
  end
endmodule

// File: rtl/exc_state_build.sv
module exc_state_build
  import exc_entry_pkg::*;
(
  input  logic [MSR_W-1:0] msr_i,
  output entry_state_t     st_o
);
  always_comb begin
    st_o.srr1         = msr_i & SRR1_COPY_MASK;
    st_o.msr          = msr_i & MSR_KEEP_MASK;
    st_o.msr[IDX_LE]  = msr_i[IDX_ILE];
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int               AW        = 32,
  parameter logic [AW-1:0]    BASE_HIGH = 32'hFFF0_0000,
  parameter logic [AW-1:0]    OFS_TRACE = 32'h0000_0D00,
  parameter logic [AW-1:0]    OFS_EMU   = 32'h0000_1000
) (
  input  logic          ip_i,
  input  cause_e        cause_i,
  output logic [AW-1:0] vec_o
);
  logic [AW-1:0] base;
  logic [AW-1:0] ofs;

  always_comb begin
    base = ip_i ? BASE_HIGH : '0;
    unique case (cause_i)
      CAUSE_EMU:   ofs = OFS_EMU;
      CAUSE_TRACE: ofs = OFS_TRACE;
      default:     ofs = '0;
    endcase
    vec_o = base + ofs;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] BASE_HIGH = 32'hFFF0_0000,
  parameter logic [AW-1:0] OFS_TRACE = 32'h0000_0D00,
  parameter logic [AW-1:0] OFS_EMU   = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic          trace_i,
  input  logic [AW-1:0] ea_i,
  input  logic [31:0]   msr_i,
  input  logic          op_unimpl_i,
  input  logic          op_fp_i,
  input  logic          spr_move_i,
  input  logic          spr_unimpl_i,
  input  logic          spr_oncore_i,
  input  logic          spr_num0_i,
  output logic          take_o,
  output logic          emu_o,
  output logic [AW-1:0] srr0_o,
  output logic [31:0]   srr1_o,
  output logic [31:0]   msr_o,
  output logic [AW-1:0] vec_o
);
  logic          emu_c;
  cause_e        cause_c;
  logic          take_c;
  entry_state_t  st_c;
  logic [AW-1:0] vec_c;

  exc_emu_classify u_cls (
    .op_unimpl_i (op_unimpl_i),
    .op_fp_i     (op_fp_i),
    .spr_move_i  (spr_move_i),
    .spr_unimpl_i(spr_unimpl_i),
    .spr_oncore_i(spr_oncore_i),
    .spr_num0_i  (spr_num0_i),
    .priv_pr_i   (msr_i[IDX_PR]),
    .emu_o       (emu_c)
  );

  // Emulation outranks trace.
  always_comb begin
    if (emu_c)        cause_c = CAUSE_EMU;
    else if (trace_i) cause_c = CAUSE_TRACE;
    else              cause_c = CAUSE_NONE;
    take_c = accept_i && (cause_c != CAUSE_NONE);
  end

  exc_state_build u_st (
    .msr_i(msr_i),
    .st_o (st_c)
  );

  exc_vector_gen #(
    .AW       (AW),
    .BASE_HIGH(BASE_HIGH),
    .OFS_TRACE(OFS_TRACE),
    .OFS_EMU  (OFS_EMU)
  ) u_vec (
    .ip_i   (msr_i[IDX_IP]),
    .cause_i(cause_c),
    .vec_o  (vec_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      emu_o  <= 1'b0;
      srr0_o <= '0;
      srr1_o <= '0;
      msr_o  <= '0;
      vec_o  <= '0;
    end else begin
      take_o <= take_c;
      if (take_c) begin
        emu_o  <= (cause_c == CAUSE_EMU);
        srr0_o <= ea_i;
        srr1_o <= st_c.srr1;
        msr_o  <= st_c.msr;
        vec_o  <= vec_c;
      end
    end
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          accept_i,
  input logic          trace_i,
  input logic [AW-1:0] ea_i,
  input logic [31:0]   msr_i,
  input logic          op_unimpl_i,
  input logic          op_fp_i,
  input logic          spr_move_i,
  input logic          spr_unimpl_i,
  input logic          spr_oncore_i,
  input logic          spr_num0_i,
  input logic          take_o,
  input logic          emu_o,
  input logic [AW-1:0] srr0_o,
  input logic [31:0]   srr1_o,
  input logic [31:0]   msr_o,
  input logic [AW-1:0] vec_o
);
  p_opcode_emu_r1: assert property (@(posedge clk) disable iff (rst)
    (accept_i && (op_unimpl_i || op_fp_i)) |=> (take_o && emu_o));

  p_oncore_spr_r2: assert property (@(posedge clk) disable iff (rst)
    (accept_i && spr_move_i && spr_unimpl_i && spr_oncore_i) |=> (take_o && emu_o));

  p_offcore_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (accept_i && spr_move_i && spr_unimpl_i && !spr_oncore_i && spr_num0_i &&
     msr_i[14] && !op_unimpl_i && !op_fp_i && !trace_i) |=> !take_o);

  p_srr0_ea_r4: assert property (@(posedge clk) disable iff (rst)
    (accept_i && (trace_i || op_unimpl_i)) |=> (srr0_o == $past(ea_i)));

  p_srr1_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (srr1_o[31:16] == 16'h0));

  p_msr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((msr_o & 32'hFFFF_EFBE) == 32'h0));

  p_vector_shape_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((vec_o[19:0] == (emu_o ? 20'h01000 : 20'h00D00)) &&
                (vec_o[31:20] == 12'h000 || vec_o[31:20] == 12'hFFF)));

  p_trace_only_r8: assert property (@(posedge clk) disable iff (rst)
    (accept_i && trace_i && !op_unimpl_i && !op_fp_i && !spr_move_i) |=> (take_o && !emu_o));

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> ($stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) && $stable(vec_o)));
endmodule

bind exc_entry_unit exc_entry_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .accept_i    (accept_i),
  .trace_i     (trace_i),
  .ea_i        (ea_i),
  .msr_i       (msr_i),
  .op_unimpl_i (op_unimpl_i),
  .op_fp_i     (op_fp_i),
  .spr_move_i  (spr_move_i),
  .spr_unimpl_i(spr_unimpl_i),
  .spr_oncore_i(spr_oncore_i),
  .spr_num0_i  (spr_num0_i),
  .take_o      (take_o),
  .emu_o       (emu_o),
  .srr0_o      (srr0_o),
  .srr1_o      (srr1_o),
  .msr_o       (msr_o),
  .vec_o       (vec_o)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accept_i = 1'b0;
  logic        trace_i = 1'b0;
  logic [31:0] ea_i = '0;
  logic [31:0] msr_i = '0;
  logic        op_unimpl_i = 1'b0;
  logic        op_fp_i = 1'b0;
  logic        spr_move_i = 1'b0;
  logic        spr_unimpl_i = 1'b0;
  logic        spr_oncore_i = 1'b0;
  logic        spr_num0_i = 1'b0;
  logic        take_o, emu_o;
  logic [31:0] srr0_o, srr1_o, msr_o, vec_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst(rst), .accept_i(accept_i), .trace_i(trace_i),
    .ea_i(ea_i), .msr_i(msr_i), .op_unimpl_i(op_unimpl_i), .op_fp_i(op_fp_i),
    .spr_move_i(spr_move_i), .spr_unimpl_i(spr_unimpl_i),
    .spr_oncore_i(spr_oncore_i), .spr_num0_i(spr_num0_i),
    .take_o(take_o), .emu_o(emu_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .msr_o(msr_o), .vec_o(vec_o)
  );

  // Bit indices: LE 0, RI 1, IP 6, ME 12, PR 14, ILE 16.
  localparam logic [31:0] B_RI  = 32'h0000_0002;
  localparam logic [31:0] B_IP  = 32'h0000_0040;
  localparam logic [31:0] B_ME  = 32'h0000_1000;
  localparam logic [31:0] B_PR  = 32'h0000_4000;
  localparam logic [31:0] B_ILE = 32'h0001_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_srr1(input logic [31:0] m);
    return {16'h0, m[15:0]};
  endfunction

  function automatic logic [31:0] exp_msr(input logic [31:0] m);
    logic [31:0] r = '0;
    r[6]  = m[6];
    r[12] = m[12];
    r[0]  = m[16];
    return r;
  endfunction

  function automatic logic [31:0] exp_vec(input logic [31:0] m, input logic emu);
    return (m[6] ? 32'hFFF0_0000 : 32'h0) + (emu ? 32'h0000_1000 : 32'h0000_0D00);
  endfunction

  // One accept with the given hints; hints = {trace,unimpl,fp,move,sunimpl,oncore,num0}.
  task automatic fire(input string tag, input logic [6:0] h, input logic [31:0] ea,
                      input logic [31:0] msr, input logic exp_take, input logic exp_emu);
    logic [31:0] p_srr0, p_srr1, p_msr, p_vec;
    logic        p_emu;
    p_srr0 = srr0_o; p_srr1 = srr1_o; p_msr = msr_o; p_vec = vec_o; p_emu = emu_o;
    @(negedge clk);
    {trace_i, op_unimpl_i, op_fp_i, spr_move_i, spr_unimpl_i, spr_oncore_i, spr_num0_i} = h;
    ea_i = ea; msr_i = msr; accept_i = 1'b1;
    @(negedge clk);
    accept_i = 1'b0;
    {trace_i, op_unimpl_i, op_fp_i, spr_move_i, spr_unimpl_i, spr_oncore_i, spr_num0_i} = '0;
    chk({tag, " take"}, {31'b0, take_o}, {31'b0, exp_take});
    if (exp_take) begin
      chk({tag, " emu"}, {31'b0, emu_o}, {31'b0, exp_emu});
      chk({tag, " R4 srr0"}, srr0_o, ea);
      chk({tag, " R5 srr1"}, srr1_o, exp_srr1(msr));
      chk({tag, " R6 msr"}, msr_o, exp_msr(msr));
      chk({tag, " R7 vec"}, vec_o, exp_vec(msr, exp_emu));
    end else begin
      chk({tag, " R9 srr0 held"}, srr0_o, p_srr0);
      chk({tag, " R9 srr1 held"}, srr1_o, p_srr1);
      chk({tag, " R9 msr held"}, msr_o, p_msr);
      chk({tag, " R9 vec held"}, vec_o, p_vec);
      chk({tag, " R9 emu held"}, {31'b0, emu_o}, {31'b0, p_emu});
    end
    @(negedge clk);
    chk({tag, " R9 pulse ends"}, {31'b0, take_o}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R10 take", {31'b0, take_o}, 32'h0);
    chk("R10 emu", {31'b0, emu_o}, 32'h0);
    chk("R10 srr0", srr0_o, 32'h0);
    chk("R10 srr1", srr1_o, 32'h0);
    chk("R10 msr", msr_o, 32'h0);
    chk("R10 vec", vec_o, 32'h0);
  endtask

  task automatic t_opcodes();
    fire("R1 unimpl", 7'b0100000, 32'h0000_2104, B_PR | B_ME, 1'b1, 1'b1);
    fire("R1 fp",     7'b0010000, 32'h0040_1000, B_ILE | 32'h0000_8001, 1'b1, 1'b1);
  endtask

  task automatic t_spr_oncore();
    fire("R2 num0=1 pr=1", 7'b0001111, 32'h1234_5678, B_PR, 1'b1, 1'b1);
    fire("R2 num0=0 pr=0", 7'b0001110, 32'h1234_567C, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_spr_offcore();
    fire("R3 num0=0 pr=1", 7'b0001100, 32'h0000_0100, B_PR, 1'b1, 1'b1);
    fire("R3 num0=1 pr=0", 7'b0001101, 32'h0000_0104, 32'h0, 1'b1, 1'b1);
    fire("R3 num0=1 pr=1 none", 7'b0001101, 32'hDEAD_0000, B_PR | B_IP, 1'b0, 1'b0);
    fire("R3 implemented none", 7'b0001010, 32'hDEAD_0004, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_trace();
    fire("R8 trace only", 7'b1000000, 32'h0000_3000, B_ME, 1'b1, 1'b0);
    fire("R8 trace+fp", 7'b1010000, 32'h0000_3004, B_ME, 1'b1, 1'b1);
    fire("R8 trace+spr", 7'b1001100, 32'h0000_3008, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_state();
    fire("R7 IP high emu", 7'b0100000, 32'hFFF0_2000, B_IP | B_RI | B_ILE, 1'b1, 1'b1);
    fire("R7 IP high trace", 7'b1000000, 32'hFFF0_2004, B_IP | B_ME, 1'b1, 1'b0);
    fire("R5 RI clear", 7'b0100000, 32'h0000_4000, 32'hFFFF_FFFD, 1'b1, 1'b1);
    fire("R6 all ones", 7'b0100000, 32'h0000_4004, 32'hFFFF_FFFF, 1'b1, 1'b1);
  endtask

  task automatic t_hold();
    fire("R9 accept no cause", 7'b0000000, 32'hAAAA_5555, 32'hFFFF_FFFF, 1'b0, 1'b0);
    @(negedge clk);
    trace_i = 1'b1; op_unimpl_i = 1'b1; ea_i = 32'h5555_AAAA;
    @(negedge clk);
    chk("R9 no accept take", {31'b0, take_o}, 32'h0);
    chk("R9 no accept srr0", srr0_o, 32'h0000_4004);
    trace_i = 1'b0; op_unimpl_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_opcodes();
    t_spr_oncore();
    t_spr_offcore();
    t_trace();
    t_state();
    t_hold();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule